// File: doc/BRIEF.md
# Misaligned Load Split-and-Merge Unit

This unit sits between a processor load port and a 16-bit memory bus that can only return the aligned word holding a given address. It takes one load request at a time, made up of an address and a size (byte or 16-bit word), and returns a 16-bit result. Byte loads and aligned word loads each need one bus read. A word load at an odd address spans two aligned bus words. In relaxed mode the unit reads both words in address order and builds the result from one byte of each. In strict mode it does no bus read at all and raises a one-cycle alignment fault that carries the offending address, so that a trap handler can emulate the access.

The sequencer has seven named states. `ST_IDLE` accepts a request. A strict-mode misaligned word load takes the transition *trap* to `ST_FAULT`; every other load takes *issue* to `ST_REQ_LO`. `ST_REQ_LO` moves to `ST_WAIT_LO` on grant. `ST_WAIT_LO` moves on read-valid, either by *split* to `ST_REQ_HI` or by *finish* to `ST_RESP`. `ST_REQ_HI` moves to `ST_WAIT_HI` on grant, and `ST_WAIT_HI` moves to `ST_RESP` on read-valid. `ST_RESP` and `ST_FAULT` both return to `ST_IDLE` after one cycle. The memory is little-endian: the lower-address byte of a bus word is bits [7:0].

Top module: `load_align_splitter`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a split, returns the unit to idle: `ld_req_ready`=1 and `ld_rsp_valid`, `ld_fault` and `mem_req` all 0.
- R2: A byte load at any address does one bus read at the address with bit 0 cleared. The result is bus bits [7:0] when address bit 0 is 0, or bus bits [15:8] when it is 1, placed in result bits [7:0] with bits [15:8] zero.
- R3: A word load at an even address does exactly one bus read, at that address, and returns the bus word unchanged.
- R4: In relaxed mode (`strict_align`=0), a word load at an odd address A does exactly two bus reads in this order: first at A with bit 0 cleared, then at that address plus 2, modulo 2^AW. The result is {second[7:0], first[15:8]}.
- R5: `ld_rsp_valid` is high for exactly one cycle per completed load, and only after all the bus reads for that load have returned.
- R6: In strict mode (`strict_align`=1), a word load at an odd address does no bus read. `ld_fault` is high for one cycle with `ld_fault_addr` equal to the request address, and no `ld_rsp_valid` is produced for that load.
- R7: Strict mode has no effect on byte loads or on word loads at even addresses.
- R8: Once `mem_req` rises, it stays high and `mem_addr` stays unchanged until the cycle in which `mem_grant` is sampled high.
- R9: `ld_req_ready` is low from the moment a request is accepted until its response or fault has been given. Requests presented during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_align | input | 1 | 1 = trap misaligned word loads, 0 = split them |
| ld_req_valid | input | 1 | Load request present |
| ld_req_ready | output | 1 | Unit idle, request accepted this cycle |
| ld_req_addr | input | AW | Byte address of the load |
| ld_req_word | input | 1 | 1 = 16-bit word load, 0 = byte load |
| ld_rsp_valid | output | 1 | One-cycle pulse, result valid |
| ld_rsp_data | output | 16 | Load result |
| ld_fault | output | 1 | One-cycle alignment fault pulse |
| ld_fault_addr | output | AW | Address of the faulting load |
| mem_req | output | 1 | Bus read request |
| mem_grant | input | 1 | Bus accepts the request |
| mem_addr | output | AW | Aligned bus read address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Aligned bus word |

## Verification
The bench targets three kinds of error. It uses word loads whose second read crosses a 256-byte line or wraps from the top of the address space to zero; a design that got the increment wrong would read the wrong word or read out of order. It uses odd-address byte loads and strict-mode requests of every kind, which catch byte lanes that are swapped, upper bytes that are not zeroed, and a trap raised on a load that should go through or a bus read issued before a fault. It holds a request with a different address on the port while a load is in progress, and it resets the unit between the two halves of a split. A unit that took the held request, or that kept a stale bus request after reset, would show extra reads or a spurious response.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_REQ_HI,
        ST_WAIT_HI,
        ST_RESP,
        ST_FAULT
    } lsa_state_e;

    typedef enum logic [1:0] {
        PH_SINGLE,
        PH_FIRST,
        PH_SECOND
    } lsa_phase_e;

endpackage

// File: rtl/lsa_classify.sv
module lsa_classify #(
    parameter int AW = 16
) (
    input  logic          strict_align,
    input  logic [AW-1:0] addr,
    input  logic          is_word,
    output logic          needs_split,
    output logic          traps
);
    logic odd_word;

    always_comb begin
        odd_word    = is_word & addr[0];
        needs_split = odd_word & ~strict_align;
        traps       = odd_word & strict_align;
    end

endmodule

// File: rtl/lsa_merge.sv
module lsa_merge #(
    parameter int DW = 16
) (
    input  lsa_pkg::lsa_phase_e phase,
    input  logic                is_word,
    input  logic                addr_lsb,
    input  logic [DW-1:0]       bus_word,
    input  logic [DW/2-1:0]     held_low,
    output logic [DW-1:0]       merged
);
    import lsa_pkg::*;
    localparam int BW = DW / 2;

    logic [BW-1:0] lo_lane;
    logic [BW-1:0] hi_lane;

    always_comb begin
        lo_lane = bus_word[BW-1:0];
        hi_lane = bus_word[DW-1:BW];
        unique case (phase)
            PH_FIRST:  merged = {{BW{1'b0}}, hi_lane};
            PH_SECOND: merged = {lo_lane, held_low};
            default: begin
                if (is_word)
                    merged = bus_word;
                else
                    merged = {{BW{1'b0}}, (addr_lsb ? hi_lane : lo_lane)};
            end
        endcase
    end

endmodule

// File: rtl/lsa_fsm.sv
module lsa_fsm #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_req_valid,
    input  logic [AW-1:0] ld_req_addr,
    input  logic          ld_req_word,
    input  logic          acc_split,
    input  logic          acc_trap,
    input  logic          mem_grant,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] merged,
    output lsa_pkg::lsa_phase_e phase,
    output logic          word_q,
    output logic          lsb_q,
    output logic [DW/2-1:0] held_low,
    output logic          ld_req_ready,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    output logic          ld_fault,
    output logic [AW-1:0] ld_fault_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr
);
    import lsa_pkg::*;
    localparam int BW = DW / 2;
    localparam logic [AW-1:0] STEP = AW'(2);

    lsa_state_e    state, state_nxt;
    logic [AW-1:0] addr_q;
    logic          split_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] base_addr;
    logic          accept;
    logic          capture;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (ld_req_valid) state_nxt = acc_trap ? ST_FAULT : ST_REQ_LO;
            ST_REQ_LO:  if (mem_grant)    state_nxt = ST_WAIT_LO;
            ST_WAIT_LO: if (mem_rvalid)   state_nxt = split_q ? ST_REQ_HI : ST_RESP;
            ST_REQ_HI:  if (mem_grant)    state_nxt = ST_WAIT_HI;
            ST_WAIT_HI: if (mem_rvalid)   state_nxt = ST_RESP;
            ST_RESP:    state_nxt = ST_IDLE;
            ST_FAULT:   state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    assign accept  = (state == ST_IDLE) && ld_req_valid;
    assign capture = ((state == ST_WAIT_LO) || (state == ST_WAIT_HI)) && mem_rvalid;

    // request and data registers
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            split_q <= 1'b0;
            word_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= ld_req_addr;
                split_q <= acc_split;
                word_q  <= ld_req_word;
            end
            if (capture) data_q <= merged;
        end
    end

    // outputs
    always_comb begin
        base_addr     = {addr_q[AW-1:1], 1'b0};
        ld_req_ready  = (state == ST_IDLE);
        ld_rsp_valid  = (state == ST_RESP);
        ld_fault      = (state == ST_FAULT);
        mem_req       = (state == ST_REQ_LO) || (state == ST_REQ_HI);
        mem_addr      = (state == ST_REQ_HI) ? base_addr + STEP : base_addr;
        ld_rsp_data   = data_q;
        ld_fault_addr = addr_q;
        lsb_q         = addr_q[0];
        held_low      = data_q[BW-1:0];
        if (state == ST_WAIT_HI)  phase = PH_SECOND;
        else if (split_q)         phase = PH_FIRST;
        else                      phase = PH_SINGLE;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_grant) |=> (mem_req && $stable(mem_addr)));

    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ld_rsp_valid |=> !ld_rsp_valid);

    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ld_fault |=> (!ld_fault && !mem_req));

    // R6
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_fault && ld_rsp_valid));

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_req_ready && ld_req_valid) |=> !ld_req_ready);

    // R2
    zext_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_rsp_valid && !word_q) |-> (ld_rsp_data[DW-1:BW] == '0));

endmodule

// File: rtl/load_align_splitter.sv
module load_align_splitter #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strict_align,
    input  logic          ld_req_valid,
    output logic          ld_req_ready,
    input  logic [AW-1:0] ld_req_addr,
    input  logic          ld_req_word,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    output logic          ld_fault,
    output logic [AW-1:0] ld_fault_addr,
    output logic          mem_req,
    input  logic          mem_grant,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    import lsa_pkg::*;
    localparam int BW = DW / 2;

    logic          acc_split;
    logic          acc_trap;
    lsa_phase_e    phase;
    logic          word_q;
    logic          lsb_q;
    logic [BW-1:0] held_low;
    logic [DW-1:0] merged;

    lsa_classify #(.AW(AW)) classify_i (
        .strict_align (strict_align),
        .addr         (ld_req_addr),
        .is_word      (ld_req_word),
        .needs_split  (acc_split),
        .traps        (acc_trap)
    );

    lsa_merge #(.DW(DW)) merge_i (
        .phase    (phase),
        .is_word  (word_q),
        .addr_lsb (lsb_q),
        .bus_word (mem_rdata),
        .held_low (held_low),
        .merged   (merged)
    );

    lsa_fsm #(.AW(AW), .DW(DW)) fsm_i (
        .clk           (clk),
        .rst           (rst),
        .ld_req_valid  (ld_req_valid),
        .ld_req_addr   (ld_req_addr),
        .ld_req_word   (ld_req_word),
        .acc_split     (acc_split),
        .acc_trap      (acc_trap),
        .mem_grant     (mem_grant),
        .mem_rvalid    (mem_rvalid),
        .merged        (merged),
        .phase         (phase),
        .word_q        (word_q),
        .lsb_q         (lsb_q),
        .held_low      (held_low),
        .ld_req_ready  (ld_req_ready),
        .ld_rsp_valid  (ld_rsp_valid),
        .ld_rsp_data   (ld_rsp_data),
        .ld_fault      (ld_fault),
        .ld_fault_addr (ld_fault_addr),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (ld_req_ready && !mem_req && !ld_rsp_valid && !ld_fault));

endmodule

// File: tb/load_align_splitter_tb_top.sv
module load_align_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strict_align = 1'b0;
    logic        ld_req_valid = 1'b0;
    logic        ld_req_ready;
    logic [15:0] ld_req_addr = '0;
    logic        ld_req_word = 1'b0;
    logic        ld_rsp_valid;
    logic [15:0] ld_rsp_data;
    logic        ld_fault;
    logic [15:0] ld_fault_addr;
    logic        mem_req;
    logic        mem_grant = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    load_align_splitter dut_i (
        .clk(clk), .rst(rst), .strict_align(strict_align),
        .ld_req_valid(ld_req_valid), .ld_req_ready(ld_req_ready),
        .ld_req_addr(ld_req_addr), .ld_req_word(ld_req_word),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .ld_fault(ld_fault), .ld_fault_addr(ld_fault_addr),
        .mem_req(mem_req), .mem_grant(mem_grant), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd29;
        return p ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model: grant after gnt_dly cycles, data one cycle after grant
    int          gnt_dly = 0;
    int          dly_cnt = 0;
    bit          pend = 0;
    logic [15:0] pend_addr = '0;
    int          rd_cnt = 0;
    logic [15:0] rd_addr [4];

    always @(negedge clk) begin
        mem_grant  = 1'b0;
        mem_rvalid = 1'b0;
        if (rst) begin
            pend = 0; dly_cnt = 0;
        end else if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = {mbyte(pend_addr + 16'd1), mbyte(pend_addr)};
            pend = 0;
        end else if (mem_req) begin
            if (dly_cnt >= gnt_dly) begin
                mem_grant = 1'b1;
                pend = 1; pend_addr = mem_addr; dly_cnt = 0;
                if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
                rd_cnt++;
            end else dly_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // {exp_reads[1:0], strict, word, addr[15:0]}; exp_reads 0 = fault expected
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {2'd1, 1'b0, 1'b0, 16'h0010},   // R2 even byte
        {2'd1, 1'b0, 1'b0, 16'h0011},   // R2 odd byte
        {2'd1, 1'b0, 1'b1, 16'h0020},   // R3 aligned word
        {2'd2, 1'b0, 1'b1, 16'h0021},   // R4 split
        {2'd2, 1'b0, 1'b1, 16'h00FF},   // R4 crosses 256-byte line
        {2'd2, 1'b0, 1'b1, 16'hFFFF},   // R4 wraps to zero
        {2'd0, 1'b1, 1'b1, 16'h0033},   // R6 trap
        {2'd1, 1'b1, 1'b1, 16'h0034},   // R7 aligned word, strict
        {2'd1, 1'b1, 1'b0, 16'h0035},   // R7 odd byte, strict
        {2'd0, 1'b1, 1'b1, 16'hFFFF},   // R6 trap at top
        {2'd2, 1'b0, 1'b1, 16'h1235},   // R4 split
        {2'd1, 1'b0, 1'b0, 16'hFFFF}    // R2 top byte
    };

    task automatic do_load(input logic [15:0] a, input logic w, input logic s,
                           input int exp_reads);
        logic [15:0] exp_data;
        logic [15:0] base;
        int rsp_n, flt_n, cyc;
        bit busy_ready;
        base = {a[15:1], 1'b0};
        exp_data = w ? {mbyte(a + 16'd1), mbyte(a)} : {8'h00, mbyte(a)};
        rd_cnt = 0; rsp_n = 0; flt_n = 0; busy_ready = 0;
        @(negedge clk);
        strict_align = s; ld_req_valid = 1'b1; ld_req_addr = a; ld_req_word = w;
        @(negedge clk);
        // R9: hold a different request while busy
        ld_req_addr = a ^ 16'h00F0; ld_req_word = ~w;
        for (cyc = 0; cyc < 60; cyc++) begin
            if (ld_rsp_valid || ld_fault) break;
            if (ld_req_ready) busy_ready = 1;
            @(negedge clk);
        end
        ld_req_valid = 1'b0;
        if (cyc >= 60) begin
            chk(0, "R5", "no response", 16'h0, 16'h1);
            return;
        end
        if (ld_rsp_valid) rsp_n++;
        if (ld_fault) flt_n++;
        chk(!busy_ready, "R9", "ready while busy", 16'(busy_ready), 16'h0);
        if (exp_reads == 0) begin
            chk(flt_n == 1 && rsp_n == 0, "R6", "fault pulse", 16'(flt_n), 16'h1);
            chk(ld_fault_addr == a, "R6", "fault address", ld_fault_addr, a);
        end else begin
            chk(rsp_n == 1 && flt_n == 0, "R5", "response pulse", 16'(rsp_n), 16'h1);
            chk(ld_rsp_data == exp_data, w ? (exp_reads == 2 ? "R4" : "R3") : "R2",
                "data", ld_rsp_data, exp_data);
        end
        chk(rd_cnt == exp_reads, exp_reads == 0 ? "R6" : "R4", "bus read count",
            16'(rd_cnt), 16'(exp_reads));
        if (exp_reads >= 1 && rd_cnt >= 1)
            chk(rd_addr[0] == base, "R4", "first read addr", rd_addr[0], base);
        if (exp_reads == 2 && rd_cnt >= 2)
            chk(rd_addr[1] == base + 16'd2, "R4", "second read addr", rd_addr[1], base + 16'd2);
        @(negedge clk);
        chk(!ld_rsp_valid && !ld_fault, "R5", "pulse length", 16'({ld_rsp_valid, ld_fault}), 16'h0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ld_req_ready && !mem_req && !ld_rsp_valid && !ld_fault, "R1", "reset state",
            16'({ld_req_ready, mem_req, ld_rsp_valid, ld_fault}), 16'h8);
        rst = 1'b0;

        foreach (VEC[i]) begin
            gnt_dly = i % 3;
            do_load(VEC[i][15:0], VEC[i][16], VEC[i][17], int'(VEC[i][19:18]));
        end

        // R1: reset between the halves of a split
        gnt_dly = 0;
        @(negedge clk);
        strict_align = 1'b0; ld_req_valid = 1'b1; ld_req_addr = 16'h0041; ld_req_word = 1'b1;
        @(negedge clk);
        ld_req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(ld_req_ready && !mem_req && !ld_rsp_valid && !ld_fault, "R1", "mid-split reset",
            16'({ld_req_ready, mem_req, ld_rsp_valid, ld_fault}), 16'h8);
        rst = 1'b0;
        // recovery load after reset
        do_load(16'h0043, 1'b1, 1'b0, 2);

        // R8: long grant delay, request must be held
        gnt_dly = 5;
        do_load(16'h0101, 1'b1, 1'b0, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule